// File: doc/BRIEF.md
# NAND Asynchronous Bus Cycle Timer

This block performs one bus cycle at a time on an asynchronous 8-bit NAND flash interface: a command latch, an address latch, a data write or a data read. Each request carries a cycle kind and a byte. The block drives the latch enables, the write and read strobes and the data bus with widths taken from two packed timing words. Each word holds four tick counts. A tick count is a nanosecond figure multiplied by the clock frequency and rounded up to a whole tick. On a read the block samples the data bus once the access delay has run out and returns the byte with a one-clock completion pulse. The flash ready/busy line is synchronised and shown in the top bit of a status word.

Requests use a valid/ready handshake. The requester holds `req_valid`, kind, byte and both timing words steady until it sees `req_ready` high at a rising edge. `req_ready` is high only while no cycle is in progress. Both timing words are captured at acceptance, so they may change freely afterwards. The response side has no back-pressure: `rsp_valid` is a single-clock pulse and `rsp_data` must be taken in that clock. A new request may be presented in the same clock as `rsp_valid` and is accepted at the following edge, so single cycles can run back to back.

Top module: `nand_cycle_timer`

## Requirements
- R1: After reset, `req_ready` is 1, `nand_we_n` and `nand_re_n` are 1, and `nand_cle`, `nand_ale`, `nand_io_oe` and `rsp_valid` are 0.
- R2: `req_kind` encodes the cycle as follows: 0 is a command, 1 is an address, 2 is a data write and 3 is a read. For kinds 0 to 2, while `nand_io_oe` is 1, `nand_io_out` equals the request byte, `nand_cle` is 1 only for kind 0 and `nand_ale` is 1 only for kind 1. `nand_cle` and `nand_ale` are never 1 together.
- R3: In a write-type cycle, `nand_we_n` is low for (write-cycle field − write-high field) clocks, or 1 clock when that difference is not positive. It is then high, with the bus still driven, for the write-high field clocks.
- R4: After the write-high phase, the latch enables and `nand_io_oe` drop and the block waits the busy-wait field clocks before completing.
- R5: A read holds `nand_re_n` high for the ready-delay field clocks and then low for the read-low field clocks. It then keeps `nand_re_n` high for the hold field clocks plus the release field clocks. `nand_io_oe` stays 0 throughout.
- R6: A read captures `nand_io_in` at the rising edge that lies access-field edges after the edge that drove `nand_re_n` low. `rsp_data` holds that byte from the completion pulse until the next read captures.
- R7: When the access delay is longer than read-low + hold + release, the read is stretched so that it completes at the capture edge.
- R8: Completion is a single-clock `rsp_valid`, raised in the clock after the last timed phase, with `req_ready` high. A write-type cycle therefore lasts low + high + wait clocks and a read lasts ready + max(low + hold + release, access) clocks from acceptance. `req_ready` is 0 from acceptance until completion.
- R9: Each timing word packs four 8-bit fields, first field in bits 31:24, then 23:16, 15:8, 7:0. `cfg_wtime` holds ready delay, busy wait, write cycle and write high, in that order. `cfg_rtime` holds access, hold, read low and release, in that order.
- R10: A timing field of zero is treated as one tick, so no phase has zero length.
- R11: `status_word[31]` equals `nand_rb` as it was two clocks earlier. Bits 30:0 are 0.
- R12: Both timing words are sampled at acceptance. Changes made during a cycle do not affect that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wtime | input | 32 | Write-side timing word |
| cfg_rtime | input | 32 | Read-side timing word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted at the edge |
| req_kind | input | 2 | Cycle kind |
| req_byte | input | 8 | Byte for command, address or write |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_data | output | 8 | Last byte read |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Data bus output value |
| nand_io_oe | output | 1 | Data bus output enable |
| nand_io_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |
| status_word | output | 32 | Status, ready/busy in bit 31 |

## Verification
Two events can land on the same edge: the read-data capture and the end of the release phase. This happens when the access field equals read-low + hold + release. The sweep over access against the other read fields provokes the capture before, at and after that edge. Each time, the bench checks that the completion pulse comes at the larger of the two and carries the byte that the bus held at the capture edge. The second coincidence is completion and acceptance. Every cycle after the first is presented in the same clock as the previous completion pulse, and the bench checks that it starts on the next edge without a lost clock.

// File: rtl/nct_pkg.sv
package nct_pkg;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_WDATA = 2'd2,
    K_READ  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    P_IDLE,
    P_WLOW,
    P_WHIGH,
    P_WWAIT,
    P_RSETUP,
    P_RLOW,
    P_RHOLD,
    P_RREL
  } phase_e;

  // field slot inside a packed timing word, slot 0 at the top
  localparam int F_RDY  = 0;
  localparam int F_WB   = 1;
  localparam int F_WC   = 2;
  localparam int F_WH   = 3;
  localparam int F_ACC  = 0;
  localparam int F_HOLD = 1;
  localparam int F_RLO  = 2;
  localparam int F_REL  = 3;
  localparam int N_FIELDS = 4;

endpackage

// File: rtl/nct_phase_timer.sv
module nct_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= len - W'(1);
    else if (cnt != '0)
      cnt <= cnt - W'(1);
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/nct_access_timer.sv
module nct_access_timer #(
  parameter int W      = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [W-1:0]      len,
  input  logic [DATA_W-1:0] bus_in,
  output logic              pending,
  output logic              fire,
  output logic [DATA_W-1:0] data_q
);
  logic [W-1:0] cnt;

  assign fire = pending && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      cnt     <= len - W'(1);
      pending <= 1'b1;
    end else if (fire) begin
      data_q  <= bus_in;
      pending <= 1'b0;
    end else if (pending) begin
      cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/nct_level_sync.sv
module nct_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nct_strobe_reg.sv
module nct_strobe_reg
  import nct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            ph_nxt,
  input  kind_e             kind_nxt,
  input  logic [DATA_W-1:0] byte_nxt,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic              io_oe,
  output logic [DATA_W-1:0] io_out
);
  logic drive;
  assign drive = (ph_nxt == P_WLOW) || (ph_nxt == P_WHIGH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cle    <= 1'b0;
      ale    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      io_oe  <= 1'b0;
      io_out <= '0;
    end else begin
      cle    <= drive && (kind_nxt == K_CMD);
      ale    <= drive && (kind_nxt == K_ADDR);
      we_n   <= (ph_nxt != P_WLOW);
      re_n   <= (ph_nxt != P_RLOW);
      io_oe  <= drive;
      io_out <= drive ? byte_nxt : '0;
    end
  end
endmodule

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer
  import nct_pkg::*;
#(
  parameter int TICK_W  = 8,
  parameter int DATA_W  = 8,
  parameter int RB_SYNC = 2,
  parameter int WORD_W  = 4 * TICK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_wtime,
  input  logic [WORD_W-1:0] cfg_rtime,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_byte,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_io_out,
  output logic              nand_io_oe,
  input  logic [DATA_W-1:0] nand_io_in,
  input  logic              nand_rb,
  output logic [WORD_W-1:0] status_word
);
  localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

  function automatic logic [TICK_W-1:0] at_least_one(input logic [TICK_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  function automatic logic [TICK_W-1:0] low_len(input logic [TICK_W-1:0] wc,
                                                input logic [TICK_W-1:0] wh);
    return (wc > wh) ? (wc - wh) : ONE;
  endfunction

  // field extraction, slot 0 in the top byte
  logic [TICK_W-1:0] in_w [N_FIELDS];
  logic [TICK_W-1:0] in_r [N_FIELDS];
  generate
    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
      assign in_w[g] = cfg_wtime[WORD_W-1-g*TICK_W -: TICK_W];
      assign in_r[g] = cfg_rtime[WORD_W-1-g*TICK_W -: TICK_W];
    end
  endgenerate

  // state
  phase_e            ph, ph_nxt;
  kind_e             kind_q, kind_nxt;
  logic [DATA_W-1:0] byte_q, byte_nxt;
  logic [TICK_W-1:0] s_wh, s_wb, s_acc, s_hold, s_rlo, s_rel;
  logic              done_q, done_nxt;

  logic              accept;
  logic              ph_load, acc_load;
  logic [TICK_W-1:0] ph_len;
  logic              ph_last;
  logic              acc_pending, acc_fire;

  assign req_ready = (ph == P_IDLE);
  assign accept    = req_valid && req_ready;
  assign kind_nxt  = accept ? kind_e'(req_kind) : kind_q;
  assign byte_nxt  = accept ? req_byte : byte_q;

  always_comb begin
    ph_nxt   = ph;
    ph_load  = 1'b0;
    ph_len   = ONE;
    acc_load = 1'b0;
    done_nxt = 1'b0;
    unique case (ph)
      P_IDLE: begin
        if (req_valid) begin
          ph_load = 1'b1;
          if (kind_e'(req_kind) == K_READ) begin
            ph_nxt = P_RSETUP;
            ph_len = at_least_one(in_w[F_RDY]);
          end else begin
            ph_nxt = P_WLOW;
            ph_len = low_len(in_w[F_WC], in_w[F_WH]);
          end
        end
      end
      P_WLOW: if (ph_last) begin
        ph_nxt  = P_WHIGH;
        ph_load = 1'b1;
        ph_len  = at_least_one(s_wh);
      end
      P_WHIGH: if (ph_last) begin
        ph_nxt  = P_WWAIT;
        ph_load = 1'b1;
        ph_len  = at_least_one(s_wb);
      end
      P_WWAIT: if (ph_last) begin
        ph_nxt   = P_IDLE;
        done_nxt = 1'b1;
      end
      P_RSETUP: if (ph_last) begin
        ph_nxt   = P_RLOW;
        ph_load  = 1'b1;
        ph_len   = at_least_one(s_rlo);
        acc_load = 1'b1;
      end
      P_RLOW: if (ph_last) begin
        ph_nxt  = P_RHOLD;
        ph_load = 1'b1;
        ph_len  = at_least_one(s_hold);
      end
      P_RHOLD: if (ph_last) begin
        ph_nxt  = P_RREL;
        ph_load = 1'b1;
        ph_len  = at_least_one(s_rel);
      end
      P_RREL: if (ph_last && (!acc_pending || acc_fire)) begin
        ph_nxt   = P_IDLE;
        done_nxt = 1'b1;
      end
      default: ph_nxt = P_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= P_IDLE;
      kind_q <= K_CMD;
      byte_q <= '0;
      done_q <= 1'b0;
      s_wh   <= '0;
      s_wb   <= '0;
      s_acc  <= '0;
      s_hold <= '0;
      s_rlo  <= '0;
      s_rel  <= '0;
    end else begin
      ph     <= ph_nxt;
      done_q <= done_nxt;
      if (accept) begin
        kind_q <= kind_e'(req_kind);
        byte_q <= req_byte;
        s_wh   <= in_w[F_WH];
        s_wb   <= in_w[F_WB];
        s_acc  <= in_r[F_ACC];
        s_hold <= in_r[F_HOLD];
        s_rlo  <= in_r[F_RLO];
        s_rel  <= in_r[F_REL];
      end
    end
  end

  nct_phase_timer #(.W(TICK_W)) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .load (ph_load),
    .len  (ph_len),
    .last (ph_last)
  );

  nct_access_timer #(.W(TICK_W), .DATA_W(DATA_W)) u_access (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (acc_load),
    .len    (at_least_one(s_acc)),
    .bus_in (nand_io_in),
    .pending(acc_pending),
    .fire   (acc_fire),
    .data_q (rsp_data)
  );

  nct_strobe_reg #(.DATA_W(DATA_W)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph_nxt  (ph_nxt),
    .kind_nxt(kind_nxt),
    .byte_nxt(byte_nxt),
    .cle     (nand_cle),
    .ale     (nand_ale),
    .we_n    (nand_we_n),
    .re_n    (nand_re_n),
    .io_oe   (nand_io_oe),
    .io_out  (nand_io_out)
  );

  logic rb_s;
  nct_level_sync #(.STAGES(RB_SYNC)) u_rb (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (nand_rb),
    .q    (rb_s)
  );

  assign status_word = {rb_s, {(WORD_W-1){1'b0}}};
  assign rsp_valid   = done_q;
endmodule

// File: rtl/nct_checks.sv
module nct_checks #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic              nand_io_oe,
  input logic [DATA_W-1:0] nand_io_out,
  input logic              nand_rb,
  input logic [WORD_W-1:0] status_word
);
  a_r2_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
    nand_cle |-> !nand_ale);

  a_r2_latch_with_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> nand_io_oe);

  a_r2_bus_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_io_oe && $past(nand_io_oe)) |-> $stable(nand_io_out));

  a_r5_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (nand_we_n && !nand_io_oe));

  a_r4_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (nand_we_n && nand_re_n && !nand_io_oe && req_ready));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r11_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (status_word[WORD_W-1] == $past(nand_rb, 2)));
endmodule

bind nand_cycle_timer nct_checks #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_nct_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_io_oe (nand_io_oe),
  .nand_io_out(nand_io_out),
  .nand_rb    (nand_rb),
  .status_word(status_word)
);

// File: tb/test_nand_cycle_timer.sv
module test_nand_cycle_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_wtime = '0, cfg_rtime = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_byte = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in;
  logic        nand_rb = 1'b0;
  logic [31:0] status_word;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always @(posedge clk) pc <= pc + 1;
  assign nand_io_in = pc[7:0];

  nand_cycle_timer i_nand_cycle_timer (
    .clk(clk), .rst_n(rst_n), .cfg_wtime(cfg_wtime), .cfg_rtime(cfg_rtime),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_byte(req_byte), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb(nand_rb), .status_word(status_word)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // called at a negedge with the block idle or in its completion clock
  task automatic run_cycle(input logic [1:0] k, input logic [7:0] b,
                           input logic [31:0] tw, input logic [31:0] tr);
    // R9 field positions
    int rdy = tw[31:24], wb = tw[23:16], wc = tw[15:8], wh = tw[7:0];
    int acc = tr[31:24], hold = tr[23:16], rlo = tr[15:8], rel = tr[7:0];
    int l_low = (wc > wh) ? (wc - wh) : 1;
    int l_high = one(wh), l_wb = one(wb);
    int l_rdy = one(rdy), l_acc = one(acc), l_rlo = one(rlo);
    int rsum = one(rlo) + one(hold) + one(rel);
    int exp_t, n = 0, lo = 0, hi = 0, wt = 0, su = 0, rl = 0;
    bit seen_lo = 0, busy_bad = 0, bus_bad = 0, zero_f;
    int pc0;
    logic [7:0] exp_d;

    chk(req_ready == 1'b1, "R8 ready at start", int'(req_ready), 1);
    req_valid = 1'b1; req_kind = k; req_byte = b;
    cfg_wtime = tw; cfg_rtime = tr;
    pc0 = pc;
    if (k == 2'd3) begin
      exp_t = l_rdy + ((l_acc > rsum) ? l_acc : rsum);
      zero_f = (rdy == 0) || (acc == 0) || (hold == 0) || (rlo == 0) || (rel == 0);
    end else begin
      exp_t = l_low + l_high + l_wb;
      zero_f = (wb == 0) || (wh == 0);
    end
    exp_d = 8'(pc0 + l_rdy + l_acc);

    while (n < 2000) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        req_valid = 1'b0;
        cfg_wtime = ~tw;   // R12: must not influence this cycle
        cfg_rtime = ~tr;
      end
      if (rsp_valid) break;
      if (req_ready) busy_bad = 1;
      if (!nand_we_n) lo++;
      if (nand_we_n && nand_io_oe) hi++;
      if (k != 2'd3 && nand_we_n && !nand_io_oe) wt++;
      if (k == 2'd3 && nand_re_n && !seen_lo) su++;
      if (!nand_re_n) begin rl++; seen_lo = 1; end
      if (nand_io_oe) begin
        if (k == 2'd3) bus_bad = 1;
        if (nand_cle != (k == 2'd0) || nand_ale != (k == 2'd1) || nand_io_out != b)
          bus_bad = 1;
      end
    end

    chk(n == exp_t + 1, "R8,R12 cycle length", n - 1, exp_t);
    chk(!busy_bad, "R8 not ready while busy", int'(busy_bad), 0);
    if (zero_f) chk(n == exp_t + 1, "R10 zero field length", n - 1, exp_t);
    if (k == 2'd3) begin
      chk(su == l_rdy, "R5 ready delay", su, l_rdy);
      chk(rl == l_rlo, "R5 read low", rl, l_rlo);
      chk(!bus_bad, "R5 bus not driven", int'(bus_bad), 0);
      chk(rsp_data == exp_d, "R6 captured byte", int'(rsp_data), int'(exp_d));
      if (l_acc > rsum) chk(n == exp_t + 1, "R7 stretched read", n - 1, exp_t);
    end else begin
      chk(lo == l_low, "R3 we low", lo, l_low);
      chk(hi == l_high, "R3 we high", hi, l_high);
      chk(wt == l_wb, "R4 busy wait", wt, l_wb);
      chk(!bus_bad, "R2 latch and bus", int'(bus_bad), 0);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && nand_we_n && nand_re_n && !nand_cle && !nand_ale &&
        !nand_io_oe && !rsp_valid, "R1 reset state", 0, 1);

    // R11 ready/busy status
    nand_rb = 1'b1;
    repeat (3) @(negedge clk);
    chk(status_word == 32'h8000_0000, "R11 status ready", int'(status_word[31]), 1);
    nand_rb = 1'b0;
    @(negedge clk);
    chk(status_word[31] == 1'b1, "R11 two-clock delay", int'(status_word[31]), 1);
    @(negedge clk);
    chk(status_word == 32'h0, "R11 status busy", int'(status_word[31]), 0);

    // R10 all-zero words
    run_cycle(2'd0, 8'h3C, 32'h0, 32'h0);
    run_cycle(2'd3, 8'h00, 32'h0, 32'h0);
    // R9 distinct fields in every slot
    run_cycle(2'd1, 8'hA7, 32'h0203_0501, 32'h0102_0304);
    run_cycle(2'd3, 8'h00, 32'h0209_0807, 32'h0302_0201);

    // write-type sweep
    for (int k = 0; k < 3; k++)
      for (int wc = 0; wc < 5; wc++)
        for (int wh = 0; wh < 4; wh++)
          for (int wb = 0; wb < 3; wb++)
            run_cycle(2'(k), 8'(8'h11 * (wc + 1) + wh * 3 + k),
                      {8'hA5, 8'(wb), 8'(wc), 8'(wh)}, 32'h5A3C_7E19);

    // read sweep, access crossing low+hold+release
    for (int rdy = 0; rdy < 3; rdy++)
      for (int acc = 0; acc < 7; acc++)
        for (int rlo = 0; rlo < 3; rlo++)
          for (int hold = 0; hold < 2; hold++)
            for (int rel = 0; rel < 3; rel++)
              run_cycle(2'd3, 8'h00, {8'(rdy), 24'h6B2D4F},
                        {8'(acc), 8'(hold), 8'(rlo), 8'(rel)});

    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule